// File: doc/BRIEF.md
# Bipolar Leaky Integrate-and-Fire Neuron

This block holds the state of one fixed-point leaky integrate-and-fire neuron and advances it by one time step each time a step strobe arrives. A signed synaptic input is aligned and added to a decaying 24-bit current. The current then feeds a decaying 24-bit voltage, together with a bias given as mantissa and exponent. The updated voltage is compared against two thresholds that are set independently. Crossing the upper one produces a positive spike. Crossing the lower one produces a negative spike.

The spike leaves the block as a 2-bit signed code with a one-cycle valid pulse. The code stays on the output until the next step. Any nonzero spike returns the voltage to zero, whatever its polarity. The decay constants, the bias and both thresholds are static configuration inputs. They are sampled on the cycle of each step, so a controller may change them between steps.

Top module: `lif3_neuron`

## Requirements
- R1: While reset is high, and on the first cycle after it, spike reads 2'b00 and spike_valid is low. Reset also clears the current and voltage to zero.
- R2: A step sampled high on a rising edge makes spike_valid high for exactly the following cycle. The spike code is updated on that same edge and then held unchanged until the next step.
- R3: On a step, the new current is the old current multiplied by (4095 − cur_decay), scaled down by 2^12. The scaling acts on the magnitude and keeps the sign. The input shifted left by 6 is then added. The magnitude of the sum is reduced modulo 2^23 and the sign is kept.
- R4: On a step, the new voltage is the sum of three terms. The first is the old voltage multiplied by (4096 − vol_decay), scaled down by 2^12 on the magnitude with the sign kept. The second is the new current. The third is bias_mant shifted left by bias_exp. The sum is clamped to the range −(2^23−1) to 2^23−1.
- R5: The spike is +1, coded 2'b01, when the new voltage is strictly greater than thr_hi·64. The comparison is made at a width that cannot overflow.
- R6: The spike is −1, coded 2'b11, when the new voltage is strictly less than thr_lo·64. The comparison is made at a width that cannot overflow.
- R7: After a +1 or −1 spike, the stored voltage is zero. After a step with no spike, it keeps the updated value.
- R8: If the voltage is above the upper threshold and below the lower threshold at the same time, the spike is 2'b00 and the voltage is not reset.
- R9: Cycles without a step change neither the current, nor the voltage, nor the spike output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance the neuron by one time step |
| act_in | input | 16 | Signed synaptic input for this step |
| cur_decay | input | 12 | Current decay constant |
| vol_decay | input | 12 | Voltage decay constant |
| bias_mant | input | 13 | Signed bias mantissa |
| bias_exp | input | 3 | Bias left-shift exponent |
| thr_hi | input | 24 | Signed upper threshold mantissa |
| thr_lo | input | 24 | Signed lower threshold mantissa |
| spike | output | 2 | Signed spike code: 00 none, 01 +1, 11 −1 |
| spike_valid | output | 1 | One-cycle pulse marking a new spike code |

## Verification
Each step's spike code and valid pulse come from a single register stage. They are due at the first rising edge after the edge that sampled the step. The bench therefore drives the step at a falling edge and compares the queued prediction at the falling edge one cycle later, which is the only cycle in which spike_valid may be high. On every other falling edge the bench checks that the code still equals the last prediction. Current and voltage are not visible at the ports. Errors in wrap, clamp, decay or reset therefore show up as a wrong spike sequence on later steps, which an independent integer model of the requirements predicts.

// File: rtl/lif3_pkg.sv
package lif3_pkg;

    localparam int STATE_W      = 24;
    localparam int IN_W         = 16;
    localparam int DECAY_SHIFT  = 12;
    localparam int DECAY_W      = DECAY_SHIFT;
    localparam int KEEP_W       = DECAY_SHIFT + 1;
    localparam int BIAS_W       = 13;
    localparam int BEXP_W       = 3;
    localparam int THR_W        = 24;
    localparam int ACT_SHIFT    = 6;
    localparam int THR_SHIFT    = 6;
    localparam int CUR_KEEP_OFS = 1;
    localparam int VOL_KEEP_OFS = 0;
    localparam int PROD_W       = STATE_W + KEEP_W + 1;
    localparam int SUM_W        = STATE_W + 3;
    localparam int CMP_W        = THR_W + THR_SHIFT + 1;

    typedef logic signed [STATE_W-1:0] state_t;
    typedef logic signed [SUM_W-1:0]   sum_t;
    typedef logic        [SUM_W-1:0]   usum_t;
    typedef logic signed [PROD_W-1:0]  prod_t;
    typedef logic        [PROD_W-1:0]  uprod_t;
    typedef logic signed [CMP_W-1:0]   cmp_t;
    typedef logic        [KEEP_W-1:0]  keep_t;

    typedef enum logic [1:0] {
        SPK_NONE = 2'b00,
        SPK_POS  = 2'b01,
        SPK_NEG  = 2'b11
    } spike_e;

    typedef struct packed {
        spike_e code;
        logic   valid;
    } spike_out_t;

    // Retention factor applied before the 2^DECAY_SHIFT division.
    function automatic keep_t keep_factor(input logic [DECAY_W-1:0] d, input int ofs);
        return keep_t'((1 << DECAY_SHIFT) - int'(d) - ofs);
    endfunction

    // Multiply by the retention factor, then divide the magnitude by 2^DECAY_SHIFT.
    function automatic state_t decay_scale(input state_t s, input keep_t k);
        prod_t  prod;
        uprod_t mag;
        logic   neg;
        prod = prod_t'(s) * prod_t'({1'b0, k});
        neg  = prod[PROD_W-1];
        mag  = neg ? uprod_t'(-prod) : uprod_t'(prod);
        mag  = mag >> DECAY_SHIFT;
        return neg ? state_t'(-mag) : state_t'(mag);
    endfunction

    function automatic sum_t widen(input state_t s);
        return sum_t'(s);
    endfunction

    // Magnitude modulo 2^(STATE_W-1), sign kept.
    function automatic state_t wrap_state(input sum_t x);
        usum_t m;
        usum_t mask;
        logic  neg;
        mask = usum_t'((64'd1 << (STATE_W - 1)) - 64'd1);
        neg  = x[SUM_W-1];
        m    = neg ? usum_t'(-x) : usum_t'(x);
        m    = m & mask;
        return neg ? state_t'(-m) : state_t'(m);
    endfunction

    // Symmetric clamp to +/-(2^(STATE_W-1) - 1).
    function automatic state_t clamp_state(input sum_t x);
        sum_t lim;
        lim = sum_t'((64'sd1 <<< (STATE_W - 1)) - 64'sd1);
        if (x > lim) begin
            return state_t'(lim);
        end
        if (x < -lim) begin
            return state_t'(-lim);
        end
        return state_t'(x);
    endfunction

    function automatic cmp_t thr_scale(input logic signed [THR_W-1:0] t);
        return cmp_t'(t) <<< THR_SHIFT;
    endfunction

endpackage

// File: rtl/lif3_current.sv
module lif3_current
    import lif3_pkg::*;
(
    input  state_t                  cur_q,
    input  logic [DECAY_W-1:0]      cur_decay,
    input  logic signed [IN_W-1:0]  act_in,
    output state_t                  cur_next
);

    keep_t  keep;
    state_t decayed;
    sum_t   aligned;
    sum_t   total;

    always_comb begin
        keep     = keep_factor(cur_decay, CUR_KEEP_OFS);
        decayed  = decay_scale(cur_q, keep);
        aligned  = sum_t'(act_in) <<< ACT_SHIFT;
        total    = widen(decayed) + aligned;
        cur_next = wrap_state(total);
    end

endmodule

// File: rtl/lif3_voltage.sv
module lif3_voltage
    import lif3_pkg::*;
(
    input  state_t                    vol_q,
    input  logic [DECAY_W-1:0]        vol_decay,
    input  state_t                    cur_next,
    input  logic signed [BIAS_W-1:0]  bias_mant,
    input  logic [BEXP_W-1:0]         bias_exp,
    output state_t                    vol_next
);

    keep_t  keep;
    state_t decayed;
    sum_t   eff_bias;
    sum_t   total;

    always_comb begin
        keep     = keep_factor(vol_decay, VOL_KEEP_OFS);
        decayed  = decay_scale(vol_q, keep);
        eff_bias = sum_t'(bias_mant) <<< bias_exp;
        total    = widen(decayed) + widen(cur_next) + eff_bias;
        vol_next = clamp_state(total);
    end

endmodule

// File: rtl/lif3_fire.sv
module lif3_fire
    import lif3_pkg::*;
(
    input  state_t                   vol_next,
    input  logic signed [THR_W-1:0]  thr_hi,
    input  logic signed [THR_W-1:0]  thr_lo,
    output spike_e                   code_next
);

    cmp_t vol_wide;
    cmp_t hi_eff;
    cmp_t lo_eff;
    logic above;
    logic below;

    always_comb begin
        vol_wide = cmp_t'(vol_next);
        hi_eff   = thr_scale(thr_hi);
        lo_eff   = thr_scale(thr_lo);
        above    = vol_wide > hi_eff;
        below    = vol_wide < lo_eff;
        unique case ({above, below})
            2'b10:   code_next = SPK_POS;
            2'b01:   code_next = SPK_NEG;
            default: code_next = SPK_NONE;
        endcase
    end

endmodule

// File: rtl/lif3_neuron.sv
module lif3_neuron
    import lif3_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      step,
    input  logic signed [15:0]        act_in,
    input  logic [11:0]               cur_decay,
    input  logic [11:0]               vol_decay,
    input  logic signed [12:0]        bias_mant,
    input  logic [2:0]                bias_exp,
    input  logic signed [23:0]        thr_hi,
    input  logic signed [23:0]        thr_lo,
    output logic [1:0]                spike,
    output logic                      spike_valid
);

    state_t     cur_q;
    state_t     vol_q;
    state_t     cur_next;
    state_t     vol_next;
    spike_e     code_next;
    spike_out_t out_q;

    lif3_current i_current (
        .cur_q     (cur_q),
        .cur_decay (cur_decay),
        .act_in    (act_in),
        .cur_next  (cur_next)
    );

    lif3_voltage i_voltage (
        .vol_q     (vol_q),
        .vol_decay (vol_decay),
        .cur_next  (cur_next),
        .bias_mant (bias_mant),
        .bias_exp  (bias_exp),
        .vol_next  (vol_next)
    );

    lif3_fire i_fire (
        .vol_next  (vol_next),
        .thr_hi    (thr_hi),
        .thr_lo    (thr_lo),
        .code_next (code_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            vol_q <= '0;
            out_q <= '{code: SPK_NONE, valid: 1'b0};
        end else begin
            out_q.valid <= step;
            if (step) begin
                cur_q      <= cur_next;
                vol_q      <= (code_next != SPK_NONE) ? state_t'(0) : vol_next;
                out_q.code <= code_next;
            end
        end
    end

    assign spike       = out_q.code;
    assign spike_valid = out_q.valid;

endmodule

// File: rtl/lif3_neuron_chk.sv
module lif3_neuron_chk
    import lif3_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       step,
    input logic [1:0] spike,
    input logic       spike_valid,
    input state_t     cur_q,
    input state_t     vol_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (spike == 2'b00 && !spike_valid));

    // R2
    valid_after_step_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> spike_valid);

    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> !spike_valid);

    // R2
    spike_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(spike));

    // R9
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(cur_q) && $stable(vol_q)));

    // R7
    fire_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (spike_valid && spike != 2'b00) |-> (vol_q == '0));

    // R4
    vol_floor_chk: assert property (@(posedge clk) disable iff (rst)
        !(vol_q[STATE_W-1] && (vol_q[STATE_W-2:0] == '0)));

    // R5
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        spike != 2'b10);

endmodule

bind lif3_neuron lif3_neuron_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .step        (step),
    .spike       (spike),
    .spike_valid (spike_valid),
    .cur_q       (cur_q),
    .vol_q       (vol_q)
);

// File: tb/test_lif3_neuron.sv
`timescale 1ns/1ps
module test_lif3_neuron;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               step = 1'b0;
    logic signed [15:0] act_in = '0;
    logic [11:0]        cur_decay = '0;
    logic [11:0]        vol_decay = '0;
    logic signed [12:0] bias_mant = '0;
    logic [2:0]         bias_exp = '0;
    logic signed [23:0] thr_hi = '0;
    logic signed [23:0] thr_lo = '0;
    logic [1:0]         spike;
    logic               spike_valid;

    always #2.5 clk = ~clk;

    lif3_neuron i_lif3_neuron (
        .clk         (clk),
        .rst         (rst),
        .step        (step),
        .act_in      (act_in),
        .cur_decay   (cur_decay),
        .vol_decay   (vol_decay),
        .bias_mant   (bias_mant),
        .bias_exp    (bias_exp),
        .thr_hi      (thr_hi),
        .thr_lo      (thr_lo),
        .spike       (spike),
        .spike_valid (spike_valid)
    );

    int         total = 0;
    int         bad = 0;
    bit         done = 0;
    bit         mon_on = 0;
    longint     m_u = 0;
    longint     m_v = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] last_exp = 2'b00;
    logic       prev_valid = 1'b0;
    string      cur_tag = "R5";
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic longint shrink(input longint p);
        return (p >= 0) ? (p >>> 12) : -((-p) >>> 12);
    endfunction

    function automatic longint wrapm(input longint x);
        longint wr;
        wr = 64'sd8388608;
        return (x >= 0) ? (x % wr) : -((-x) % wr);
    endfunction

    function automatic longint clampv(input longint x);
        longint lim;
        lim = 64'sd8388607;
        if (x > lim) return lim;
        if (x < -lim) return -lim;
        return x;
    endfunction

    // Independent integer model of R3..R8
    task automatic predict(output logic [1:0] code);
        longint thi;
        longint tlo;
        bit     pos;
        bit     neg;
        m_u = wrapm(shrink(m_u * (64'sd4095 - longint'(cur_decay))) + longint'(act_in) * 64);
        m_v = clampv(shrink(m_v * (64'sd4096 - longint'(vol_decay))) + m_u
                     + longint'(bias_mant) * (64'sd1 << bias_exp));
        thi = longint'(thr_hi) * 64;
        tlo = longint'(thr_lo) * 64;
        pos = m_v > thi;
        neg = m_v < tlo;
        if (pos && !neg) begin
            code = 2'b01;
            m_v  = 0;
        end else if (neg && !pos) begin
            code = 2'b11;
            m_v  = 0;
        end else begin
            code = 2'b00;
        end
    endtask

    task automatic do_step(input logic signed [15:0] a, input int gap);
        logic [1:0] c;
        @(negedge clk);
        act_in = a;
        step   = 1'b1;
        predict(c);
        exp_q.push_back(c);
        tag_q.push_back(cur_tag);
        @(negedge clk);
        step = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic set_cfg(input int du, input int dv, input int bm, input int be,
                           input int hi, input int lo);
        cur_decay = 12'(du);
        vol_decay = 12'(dv);
        bias_mant = 13'(bm);
        bias_exp  = 3'(be);
        thr_hi    = 24'(hi);
        thr_lo    = 24'(lo);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        check(exp_q.size() == 0, "R2", "pending results before reset", exp_q.size(), 0);
        mon_on = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state after reset
        check(spike == 2'b00, "R1", "spike after reset", spike, 0);
        check(!spike_valid, "R1", "valid after reset", spike_valid, 0);
        m_u = 0;
        m_v = 0;
        last_exp = 2'b00;
        prev_valid = 1'b0;
        mon_on = 1;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        logic [1:0] e;
        string      t;
        if (mon_on) begin
            if (spike_valid) begin
                check(!prev_valid, "R2", "valid wider than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "valid with no step", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(spike == e, t, "spike code", spike, e);
                    last_exp = e;
                end
            end else begin
                // R2 / R9: code held between steps
                check(spike == last_exp, "R9", "spike held between steps", spike, last_exp);
            end
            prev_valid = spike_valid;
        end
    end

    initial begin
        #100000.0;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(spike == 2'b00, "R1", "spike after power-up reset", spike, 0);
        check(!spike_valid, "R1", "valid after power-up reset", spike_valid, 0);
        mon_on = 1;

        // R5: fires only when strictly above, R7: restart from zero
        cur_tag = "R5";
        set_cfg(4095, 0, 0, 0, 100, -100);
        for (int i = 0; i < 3; i++) do_step(16'sd50, 1);
        cur_tag = "R7";
        for (int i = 0; i < 6; i++) do_step(16'sd50, 0);

        // R6: negative polarity
        apply_reset();
        cur_tag = "R6";
        for (int i = 0; i < 6; i++) do_step(-16'sd50, 1);

        // R8: overlapping thresholds
        apply_reset();
        cur_tag = "R8";
        set_cfg(4095, 0, 0, 0, -10, 10);
        for (int i = 0; i < 3; i++) do_step(16'sd0, 0);
        for (int i = 0; i < 3; i++) do_step(16'sd20, 0);

        // R4: bias mantissa/exponent
        apply_reset();
        cur_tag = "R4";
        set_cfg(4095, 0, 5, 3, 5, -1000);
        for (int i = 0; i < 12; i++) do_step(16'sd0, 0);

        // R4: voltage decay
        apply_reset();
        set_cfg(4095, 2048, 0, 0, 70, -1000);
        for (int i = 0; i < 8; i++) do_step(16'sd50, 0);

        // R3: current accumulation and wrap
        apply_reset();
        cur_tag = "R3";
        set_cfg(0, 4095, 0, 0, 100000, -100000);
        for (int i = 0; i < 10; i++) do_step(16'sd32767, 0);
        set_cfg(2048, 4095, 0, 0, 20, -20);
        for (int i = 0; i < 6; i++) do_step(16'sd0, 0);

        // R4 positive clamp, then R5 at the clamp value
        apply_reset();
        cur_tag = "R4";
        set_cfg(4095, 0, 4095, 7, 8388607, -8388608);
        for (int i = 0; i < 6; i++) do_step(16'sd32767, 0);
        cur_tag = "R5";
        set_cfg(4095, 0, 4095, 7, 131071, -8388608);
        do_step(16'sd32767, 0);

        // R4 negative clamp, then R6 at the clamp value
        apply_reset();
        cur_tag = "R4";
        set_cfg(4095, 0, -4096, 7, 8388607, -8388608);
        for (int i = 0; i < 6; i++) do_step(-16'sd32768, 0);
        cur_tag = "R6";
        set_cfg(4095, 0, -4096, 7, 8388607, -131071);
        do_step(-16'sd32768, 0);

        // R9: long idle gaps between steps
        apply_reset();
        cur_tag = "R9";
        set_cfg(100, 200, 3, 1, 1000, -1000);
        for (int i = 0; i < 8; i++) do_step(16'(i * 900 - 2000), 7);

        // R3/R4/R5/R6 mixed pattern
        apply_reset();
        cur_tag = "R3";
        set_cfg(300, 500, -3, 2, 3000, -2500);
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_step(lfsr, i % 3);
        end

        apply_reset();
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2", "results left unconsumed", exp_q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule